// File: doc/BRIEF.md
# Dual-channel serial DAC register controller

This block is the digital control core of a two-channel digital-to-analog converter. A host writes to it over a three-wire serial slave port that has a chip select, a serial clock and a data input. All three pins are oversampled in one system clock domain.

Each 16-bit word starts with a three-bit operation prefix followed by a 13-bit field. The prefix chooses one of several actions:
- load a channel's input register without touching its DAC register;
- load an input register and then transfer both input registers into the DAC registers;
- write both input and DAC registers directly;
- transfer only;
- shut down one or both channels.

When the prefix is all zeros, the top four field bits become a sub-command. These sub-commands drive a general-purpose output, pick the clock edge for serial data out, and update or shut down a single channel.

Serial data out is the far end of the internal 16-bit shift register, so several blocks can be daisy-chained. A lockout pin vetoes shutdown and wakes both channels at once. An active-low clear returns everything to the power-up state.

Top module: `dual_dac_ctrl`

## Requirements
- R1: SDI is shifted in MSB first on each rising SCLK edge, but only while CS_N is low. The command held in the shift register is applied once, on the rising edge of CS_N. SCLK edges while CS_N is high change neither the shift register nor any output.
- R2: The DAC codes change only when a command is applied.
- R3: Operation prefix (bits 15..13) 001 loads input register A, and 101 loads input register B, from bits 12..0. Neither DAC code changes.
- R4: Prefix 010 loads input register A and prefix 110 loads input register B. In the same command, both DAC codes then take their input registers, including the word just loaded.
- R5: Prefix 011 writes bits 12..0 into both input registers and both DAC codes. Prefix 100 copies each input register to its DAC code, and its field is ignored.
- R6: With prefix 000, bits 12..10 form a sub-command:
  - 000: no operation.
  - 001: DAC A takes input A.
  - 101: DAC B takes input B.
  - 010: GPO goes low.
  - 011: GPO goes high.
  - 100: selects the serial-out edge from bit 9 (1 = rising, 0 = falling).
- R7: Prefix 111 shuts down both channels. Sub-command 110 shuts down channel A and 111 shuts down channel B. A shutdown command has an effect only while LOCKOUT is high, and its remaining field bits are ignored.
- R8: While LOCKOUT is low, both shutdown flags read 0 without waiting for a clock. The shutdown state is cleared, so both flags stay 0 after LOCKOUT returns high, and the DAC codes are kept.
- R9: Any load or transfer that touches a channel clears that channel's shutdown flag, and does not affect the other channel. Input registers keep their contents through shutdown.
- R10: CLR_N low clears the following to 0: both input registers, both DAC codes, the shift register, GPO, SDO and both shutdown flags. It also selects falling-edge serial out.
- R11: SDO is the last stage of the shift register. In falling-edge mode it changes on falling SCLK edges. In rising-edge mode it changes on rising SCLK edges. While the next frame is shifted, the value after edge k (k = 1..15) is bit 15-k of the previous frame.
- R12: A frame with more or fewer than 16 clocks applies the last 16 bits held in the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| clr_n | input | 1 | Asynchronous active-low clear, also used as power-up reset |
| cs_n | input | 1 | Active-low chip select; its rising edge applies the frame |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| lockout | input | 1 | High allows shutdown; low forces both channels awake |
| dac_a | output | 13 | Code of channel A |
| dac_b | output | 13 | Code of channel B |
| sleep_a | output | 1 | Channel A shut down |
| sleep_b | output | 1 | Channel B shut down |
| gpo | output | 1 | General-purpose output driven by command |
| sdo | output | 1 | Serial data out for daisy chaining |

## Verification
Two actions can meet in one cycle.

The first pair is the input-register write and the DAC transfer of a load-and-update command. The DAC must take the new word, not the stale one. This is provoked by loading a channel with one value and then sending load-and-update with a different value. The bench model requires the fresh word on the same channel and the held word on the other.

The second pair is a shutdown command and a low lockout, where the veto must win. Shutdown frames are sent with lockout low, and the bench checks that both flags are still clear after lockout rises again. The constrained-random stream also toggles lockout between frames, so that shutdown, wake and veto are interleaved.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;

  localparam int NCH   = 2;
  localparam int OP_W  = 3;
  localparam int SUB_W = 4;

  typedef struct packed {
    logic [NCH-1:0] ld_in;
    logic [NCH-1:0] upd;
    logic           ld_all;
    logic [NCH-1:0] sd;
    logic           gpo_we;
    logic           gpo_val;
    logic           mode_we;
    logic           mode_val;
  } cmd_t;

  // Turn operation prefix and sub-command nibble into per-channel actions.
  function automatic cmd_t decode_cmd(input logic [OP_W-1:0] op,
                                      input logic [SUB_W-1:0] sub);
    cmd_t c;
    c = '0;
    unique case (op)
      3'b001: c.ld_in[0] = 1'b1;
      3'b101: c.ld_in[1] = 1'b1;
      3'b010: begin c.ld_in[0] = 1'b1; c.upd = '1; end
      3'b110: begin c.ld_in[1] = 1'b1; c.upd = '1; end
      3'b011: c.ld_all = 1'b1;
      3'b100: c.upd = '1;
      3'b111: c.sd = '1;
      default: begin
        case (sub[3:1])
          3'b001: c.upd[0] = 1'b1;
          3'b101: c.upd[1] = 1'b1;
          3'b010: begin c.gpo_we = 1'b1; c.gpo_val = 1'b0; end
          3'b011: begin c.gpo_we = 1'b1; c.gpo_val = 1'b1; end
          3'b100: begin c.mode_we = 1'b1; c.mode_val = sub[0]; end
          3'b110: c.sd[0] = 1'b1;
          3'b111: c.sd[1] = 1'b1;
          default: ;
        endcase
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dac_bit_sync.sv
module dac_bit_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               sclk_s,
  input  logic               csn_s,
  input  logic               sdi_s,
  input  logic               mode_rise,
  output logic [FRAME_W-1:0] frame,
  output logic               apply,
  output logic               sck_edge,
  output logic               sdo
);
  logic sclk_d, csn_d;
  logic sck_rise, sck_fall;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  assign sck_rise = sclk_s & ~sclk_d & ~csn_s;
  assign sck_fall = ~sclk_s & sclk_d & ~csn_s;
  assign sck_edge = sck_rise | sck_fall;
  assign apply    = csn_s & ~csn_d;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      frame <= '0;
      sdo   <= 1'b0;
    end else begin
      if (sck_rise) frame <= {frame[FRAME_W-2:0], sdi_s};
      if (sck_rise && mode_rise)       sdo <= frame[FRAME_W-2];
      else if (sck_fall && !mode_rise) sdo <= frame[FRAME_W-1];
    end
  end
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs #(
  parameter int CODE_W = 13
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              lock_s,
  input  logic [CODE_W-1:0] data,
  input  logic              ld_in,
  input  logic              upd,
  input  logic              ld_all,
  input  logic              sd,
  output logic [CODE_W-1:0] code,
  output logic              sleep_q
);
  logic [CODE_W-1:0] in_q;
  logic              wake;

  assign wake = ld_in | upd | ld_all;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      in_q    <= '0;
      code    <= '0;
      sleep_q <= 1'b0;
    end else begin
      if (ld_in || ld_all) in_q <= data;
      if (ld_all)   code <= data;
      else if (upd) code <= ld_in ? data : in_q;
      if (!lock_s)   sleep_q <= 1'b0;
      else if (wake) sleep_q <= 1'b0;
      else if (sd)   sleep_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dual_dac_pkg::*;
#(
  parameter int CODE_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              lockout,
  output logic [CODE_W-1:0] dac_a,
  output logic [CODE_W-1:0] dac_b,
  output logic              sleep_a,
  output logic              sleep_b,
  output logic              gpo,
  output logic              sdo
);
  localparam int FRAME_W = CODE_W + OP_W;
  localparam int NPIN    = 4;
  localparam logic [NPIN-1:0] RST_PAT = 4'b1001; // lockout, sdi, sclk, cs_n

  logic [NPIN-1:0] pin_raw, pin_s;
  logic csn_s, sclk_s, sdi_s, lock_s;

  assign pin_raw = {lockout, sdi, sclk, cs_n};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    dac_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RST_PAT[g])) u_sync (
      .clk(clk), .clr_n(clr_n), .d(pin_raw[g]), .q(pin_s[g]));
  end

  assign {lock_s, sdi_s, sclk_s, csn_s} = pin_s;

  // Named internal events for the checker.
  logic [FRAME_W-1:0] frame;
  logic               apply;
  logic               sck_edge;
  logic               mode_q, gpo_q;
  logic [NCH-1:0]     sleep_q;

  dac_serial_front #(.FRAME_W(FRAME_W)) u_front (
    .clk(clk), .clr_n(clr_n), .sclk_s(sclk_s), .csn_s(csn_s), .sdi_s(sdi_s),
    .mode_rise(mode_q), .frame(frame), .apply(apply), .sck_edge(sck_edge),
    .sdo(sdo));

  logic [CODE_W-1:0] fdata;
  cmd_t              cmd_raw, cmd;

  assign fdata   = frame[CODE_W-1:0];
  assign cmd_raw = decode_cmd(frame[FRAME_W-1 -: OP_W], frame[CODE_W-1 -: SUB_W]);
  assign cmd     = apply ? cmd_raw : '0;

  logic [NCH-1:0][CODE_W-1:0] codes;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dac_chan_regs #(.CODE_W(CODE_W)) u_ch (
      .clk(clk), .clr_n(clr_n), .lock_s(lock_s), .data(fdata),
      .ld_in(cmd.ld_in[c]), .upd(cmd.upd[c]), .ld_all(cmd.ld_all),
      .sd(cmd.sd[c]), .code(codes[c]), .sleep_q(sleep_q[c]));
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      gpo_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (cmd.gpo_we)  gpo_q  <= cmd.gpo_val;
      if (cmd.mode_we) mode_q <= cmd.mode_val;
    end
  end

  assign dac_a   = codes[0];
  assign dac_b   = codes[1];
  assign sleep_a = sleep_q[0] & lockout;
  assign sleep_b = sleep_q[1] & lockout;
  assign gpo     = gpo_q;
endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk #(
  parameter int CODE_W = 13
) (
  input logic                clk,
  input logic                clr_n,
  input logic                apply,
  input logic [CODE_W+2:0]   frame,
  input logic [CODE_W-1:0]   dac_a,
  input logic [CODE_W-1:0]   dac_b,
  input logic                gpo,
  input logic                sdo,
  input logic                sck_edge,
  input logic                lock_s,
  input logic [1:0]          sleep_q
);
  // R2
  dac_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !apply |=> ($stable(dac_a) && $stable(dac_b)));

  // R3
  load_only_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (apply && frame[CODE_W+2 -: 3] == 3'b001) |=> ($stable(dac_a) && $stable(dac_b)));

  // R5
  direct_load_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (apply && frame[CODE_W+2 -: 3] == 3'b011) |=>
      (dac_a == $past(frame[CODE_W-1:0]) && dac_b == $past(frame[CODE_W-1:0])));

  // R8
  lock_wake_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !lock_s |=> (sleep_q == 2'b00));

  // R6
  gpo_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !apply |=> $stable(gpo));

  // R11
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !sck_edge |=> $stable(sdo));
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .clr_n(clr_n), .apply(apply), .frame(frame), .dac_a(dac_a),
  .dac_b(dac_b), .gpo(gpo), .sdo(sdo), .sck_edge(sck_edge), .lock_s(lock_s),
  .sleep_q(sleep_q));

// File: tb/dual_dac_ctrl_test.sv
`timescale 1ns/1ps
module dual_dac_ctrl_test;
  logic clk = 1'b0;
  logic clr_n, cs_n, sclk, sdi, lockout;
  logic [12:0] dac_a, dac_b;
  logic sleep_a, sleep_b, gpo, sdo;

  always #2.5 clk = ~clk;

  dual_dac_ctrl uut (
    .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .lockout(lockout), .dac_a(dac_a), .dac_b(dac_b), .sleep_a(sleep_a),
    .sleep_b(sleep_b), .gpo(gpo), .sdo(sdo));

  int nchk = 0, nerr = 0;
  bit done = 0;

  logic [12:0] m_in [2];
  logic [12:0] m_dac [2];
  logic        m_sleep [2];
  logic        m_gpo, m_mode;
  logic [15:0] m_shreg;
  logic        cap_r [1:32];
  logic        cap_f [1:32];

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(int n = 6);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_in[c] = '0; m_dac[c] = '0; m_sleep[c] = 1'b0;
    end
    m_gpo = 1'b0; m_mode = 1'b0; m_shreg = '0;
  endtask

  // Independent restatement of the command table.
  task automatic model_apply(logic [15:0] f);
    logic [12:0] d;
    d = f[12:0];
    case (f[15:13])
      3'd1: begin m_in[0] = d; m_sleep[0] = 0; end
      3'd5: begin m_in[1] = d; m_sleep[1] = 0; end
      3'd2: begin m_in[0] = d; m_dac[0] = m_in[0]; m_dac[1] = m_in[1];
                  m_sleep[0] = 0; m_sleep[1] = 0; end
      3'd6: begin m_in[1] = d; m_dac[0] = m_in[0]; m_dac[1] = m_in[1];
                  m_sleep[0] = 0; m_sleep[1] = 0; end
      3'd3: begin m_in[0] = d; m_in[1] = d; m_dac[0] = d; m_dac[1] = d;
                  m_sleep[0] = 0; m_sleep[1] = 0; end
      3'd4: begin m_dac[0] = m_in[0]; m_dac[1] = m_in[1];
                  m_sleep[0] = 0; m_sleep[1] = 0; end
      3'd7: if (lockout) begin m_sleep[0] = 1; m_sleep[1] = 1; end
      default: begin
        if (d[12:10] == 3'b001) begin m_dac[0] = m_in[0]; m_sleep[0] = 0; end
        if (d[12:10] == 3'b101) begin m_dac[1] = m_in[1]; m_sleep[1] = 0; end
        if (d[12:10] == 3'b010) m_gpo = 1'b0;
        if (d[12:10] == 3'b011) m_gpo = 1'b1;
        if (d[12:10] == 3'b100) m_mode = d[9];
        if (d[12:10] == 3'b110 && lockout) m_sleep[0] = 1;
        if (d[12:10] == 3'b111 && lockout) m_sleep[1] = 1;
      end
    endcase
  endtask

  task automatic send_bits(int n, logic [31:0] v, bit hold_cs_high);
    if (!hold_cs_high) cs_n = 1'b0;
    hw();
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      hw();
      sclk = 1'b1;
      if (!hold_cs_high) m_shreg = {m_shreg[14:0], v[i]};
      hw();
      cap_r[n-i] = sdo;
      sclk = 1'b0;
      hw();
      cap_f[n-i] = sdo;
    end
    if (!hold_cs_high) begin
      cs_n = 1'b1;
      hw(8);
      model_apply(m_shreg);
    end
  endtask

  task automatic send(logic [15:0] f);
    send_bits(16, {16'h0, f}, 1'b0);
  endtask

  task automatic set_lock(logic v);
    lockout = v;
    if (!v) begin m_sleep[0] = 0; m_sleep[1] = 0; end
    hw();
  endtask

  task automatic check_all(string req);
    chk({req, " dac_a"}, {3'b0, dac_a}, {3'b0, m_dac[0]});
    chk({req, " dac_b"}, {3'b0, dac_b}, {3'b0, m_dac[1]});
    chk({req, " sleep_a"}, {15'b0, sleep_a}, {15'b0, m_sleep[0] & lockout});
    chk({req, " sleep_b"}, {15'b0, sleep_b}, {15'b0, m_sleep[1] & lockout});
    chk({req, " gpo"}, {15'b0, gpo}, {15'b0, m_gpo});
  endtask

  task automatic do_clear();
    clr_n = 1'b0;
    hw(3);
    model_reset();
    clr_n = 1'b1;
    hw(4);
  endtask

  // SDO during frame y must replay frame x, one bit per active edge.
  task automatic sdo_pair(logic [15:0] x, logic [15:0] y, bit rising);
    send(x);
    send(y);
    for (int k = 1; k <= 15; k++)
      chk(rising ? "R11 sdo rising" : "R11 sdo falling",
          {15'b0, rising ? cap_r[k] : cap_f[k]}, {15'b0, x[15-k]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [15:0] f;
    void'($urandom(32'h5A17));
    clr_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; lockout = 1'b1;
    model_reset();
    hw(4);
    clr_n = 1'b1;
    hw(4);
    check_all("R10 reset");
    chk("R10 sdo reset", {15'b0, sdo}, 16'h0);

    // R3 load only, then R6 single-channel transfer
    send(16'h3ABC);               // 001, A
    check_all("R3 load A");
    send(16'hA0F0);               // 101, B
    check_all("R3 load B");
    send(16'h0400);               // sub 001: DAC A <- input A
    check_all("R6 update A");
    send(16'h1400);               // sub 101: DAC B <- input B
    check_all("R6 update B");

    // R4 load-and-update uses the fresh word
    send(16'h2000 | 16'h0123);    // 001 A=0123
    send(16'h4000 | 16'h1F00);    // 010 A=1F00 then both update
    check_all("R4 load A update");
    send(16'hC000 | 16'h0AAA);    // 110 B=0AAA then both update
    check_all("R4 load B update");

    // R5 direct and transfer-only (data ignored)
    send(16'h6000 | 16'h1555);
    check_all("R5 direct both");
    send(16'h2000 | 16'h0042);
    send(16'hA000 | 16'h0777);
    send(16'h8000 | 16'h1FFF);
    check_all("R5 transfer both");

    // R6 general-purpose output
    send(16'h0C00);
    check_all("R6 gpo high");
    send(16'h0800);
    check_all("R6 gpo low");
    send(16'h01FF);
    check_all("R6 nop");

    // R7 shutdown, R8 lockout wake
    send(16'hFFFF);
    check_all("R7 shut both");
    lockout = 1'b0;
    #1;
    chk("R8 async wake a", {15'b0, sleep_a}, 16'h0);
    chk("R8 async wake b", {15'b0, sleep_b}, 16'h0);
    set_lock(1'b0);
    set_lock(1'b1);
    check_all("R8 stays awake");
    set_lock(1'b0);
    send(16'hE000);
    set_lock(1'b1);
    check_all("R7 veto by lockout");

    // R9 per-channel wake
    send(16'h1800);               // sub 110: shut A
    check_all("R7 shut A");
    send(16'h1400);               // update B only
    check_all("R9 B does not wake A");
    send(16'h2000 | 16'h0999);    // load A wakes A, DAC unchanged
    check_all("R9 load wakes A");
    send(16'h1C00);               // shut B
    send(16'h8000);               // transfer both wakes B
    check_all("R9 transfer wakes B");

    // R1 clocks with CS_N high are ignored; R12 odd-length frames
    send_bits(8, 32'h0000_00FF, 1'b1);
    check_all("R1 cs high ignored");
    send_bits(20, 32'h000F_6123, 1'b0);
    check_all("R12 long frame");
    send_bits(8, 32'h0000_00C3, 1'b0);
    check_all("R12 short frame");

    // R11 serial out in both modes
    sdo_pair(16'h01A5, 16'h0000, 1'b0);
    send(16'h1200);
    chk("R6 mode rising", {15'b0, m_mode}, 16'h1);
    sdo_pair(16'h015A, 16'h0000, 1'b1);
    send(16'h1000);
    chk("R6 mode falling", {15'b0, m_mode}, 16'h0);

    // Constrained random mix
    for (int it = 0; it < 60; it++) begin
      if ($urandom_range(7) == 0) set_lock(~lockout);
      f = 16'($urandom);
      if ($urandom_range(3) == 0) f[15:13] = 3'b000;
      send(f);
      check_all("R2 random");
    end
    set_lock(1'b1);

    // R10 clear mid-run
    send(16'h6000 | 16'h1234);
    send(16'h0C00);
    send(16'hFFFF);
    do_clear();
    check_all("R10 clear");
    sdo_pair(16'h0133, 16'h0000, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule